// File: doc/BRIEF.md
# Firmware Flash Write Guard with SMI Trap

This block holds the two chipset registers that decide whether software may write the firmware flash. A byte-wide flash control register carries a write-enable bit and two protection bits. A 32-bit interrupt control register carries the global enable for system management interrupts (SMI) and a lock that freezes that enable. Software reaches both registers through a single-cycle register port. The block drives the flash controller's write permission and a level SMI request toward the processor.

When either protection bit is set and software raises write-enable from 0 to 1, the block raises an SMI. Firmware running in the SMI handler can then drop write-enable through a dedicated clear input, and it acknowledges the request. Clearing the global SMI enable suppresses every SMI. This means write-enable then stays set even under protection. The lock bit exists to prevent exactly that bypass.

The two protection bits and the interrupt lock can only be set. Only the synchronous system reset returns them to 0. One generic SMI source input is also gated by the global enable.

Top module: `bwl_smi_ctrl`

## Requirements
- R1: After synchronous active-low reset, both registers read 0, `flash_wr_en` is 0 and `smi_req` is 0.
- R2: A write with `reg_sel`=0 loads write-enable from data bit 0. `flash_wr_en` equals the stored write-enable from the next cycle. With protect bits 1 and 5 both 0, no write raises an SMI.
- R3: Bit 1 (lock) and bit 5 (write-protect) of the flash control register are set by a written 1 and are never cleared by a write.
- R4: A flash control write that takes write-enable from 0 to 1 while bit 1 or bit 5 is already 1 and the global enable is 1 asserts `smi_req` on the same clock edge that sets write-enable. Write-enable is still set. A write of 1 when write-enable is already 1 raises no SMI.
- R5: While the global SMI enable (bit 0 of the interrupt control register, `reg_sel`=1) is 0, neither the write trap nor `ext_smi` asserts `smi_req`.
- R6: `smi_req` stays high until a cycle with `smi_ack`=1 and no new trigger. A trigger in the same cycle as the acknowledge keeps it high.
- R7: `smm_we_clr`=1 clears write-enable on the next edge and wins over a software write of 1 in the same cycle.
- R8: Bit 1 of the interrupt control register (interrupt lock) is set-only. While it is 1, written values of the global enable are ignored. While it is 0, the global enable can be written to 0 or 1.
- R9: A cycle with `ext_smi`=1 and the global enable at 1 asserts `smi_req` on the next edge.
- R10: Reads return the register picked by `reg_sel` on the same cycle. Flash control bits other than 0, 1 and 5 read 0. Interrupt control bits other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flash control register, 1 = interrupt control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| smm_we_clr | input | 1 | Handler clear of write-enable |
| ext_smi | input | 1 | Generic SMI source |
| smi_ack | input | 1 | Acknowledge pulse for the SMI request |
| flash_wr_en | output | 1 | Write permission toward the flash controller |
| smi_req | output | 1 | Level SMI request |

## Verification
The write trap is swept over every combination of the two protect bits, the global enable, the prior write-enable and the written value. This separates a true 0-to-1 transition from a rewrite of 1, and separates gating by protection from gating by the global enable. The interrupt lock is swept over both prior enable values and both written values, locked and unlocked. A lock that is stuck open and a lock that freezes too early therefore both show. Further patterns collide the acknowledge with a new trigger, and collide the handler clear with a software set. All-ones writes expose the read layout.

// File: rtl/bwl_pkg.sv
// Package: bit positions and register selector shared by the write-guard block.
// Assumes a single 32-bit register port, one register written per cycle.
package bwl_pkg;
    localparam int DATA_W  = 32;
    // flash control register bit positions
    localparam int FC_WE   = 0;
    localparam int FC_LOCK = 1;
    localparam int FC_WP   = 5;
    // interrupt control register bit positions
    localparam int IC_GEN  = 0;
    localparam int IC_LOCK = 1;

    typedef enum logic {
        SEL_FLASH = 1'b0,
        SEL_INTR  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/bwl_flash_ctl.sv
// Flash control register: write-enable plus two set-only protection bits.
// Reports a protected 0-to-1 write-enable attempt; handler clear wins over a set.
module bwl_flash_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wd_we,
    input  logic wd_lock,
    input  logic wd_wp,
    input  logic we_clr,
    output logic we,
    output logic lock,
    output logic wp,
    output logic trap
);
    // trap: a software raise of write-enable while protection is active
    always_comb trap = wr && wd_we && !we && (lock || wp);

    // register update: sticky protection bits, handler clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we   <= 1'b0;
            lock <= 1'b0;
            wp   <= 1'b0;
        end else begin
            if (wr) begin
                lock <= lock | wd_lock;
                wp   <= wp | wd_wp;
            end
            if (we_clr)  we <= 1'b0;
            else if (wr) we <= wd_we;
        end
    end
endmodule

// File: rtl/bwl_intr_ctl.sv
// Interrupt control register: global SMI enable and a set-only lock freezing it.
// Assumes the enable update uses the lock value held before the write.
module bwl_intr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wd_gen,
    input  logic wd_lock,
    output logic gen,
    output logic lock
);
    // register update: enable writable only while unlocked, lock sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen  <= 1'b0;
            lock <= 1'b0;
        end else if (wr) begin
            if (!lock) gen <= wd_gen;
            lock <= lock | wd_lock;
        end
    end
endmodule

// File: rtl/bwl_smi_req.sv
// SMI request generator: a level set by any gated source, dropped on acknowledge.
// Assumes N_SRC sources; a new trigger wins over a simultaneous acknowledge.
module bwl_smi_req #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             gen,
    input  logic             ack,
    output logic             req
);
    logic hit;

    // gate all sources by the global enable
    always_comb hit = gen && (|src);

    // request level: set on hit, clear on ack otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   req <= 1'b0;
        else if (hit) req <= 1'b1;
        else if (ack) req <= 1'b0;
    end
endmodule

// File: rtl/bwl_smi_ctrl.sv
// Top: firmware flash write guard with SMI trap.
// Decodes the register port, reads back the selected register combinationally,
// and routes the protected-write trap and the generic source to the SMI request.
module bwl_smi_ctrl
    import bwl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          smm_we_clr,
    input  logic          ext_smi,
    input  logic          smi_ack,
    output logic          flash_wr_en,
    output logic          smi_req
);
    localparam int N_SRC = 2;

    logic wr_flash, wr_intr;
    logic fc_we, fc_lock, fc_wp, fc_trap;
    logic ic_gen, ic_lock;
    logic [N_SRC-1:0] smi_src;
    logic wdata_unused;

    // write decode by selector
    always_comb begin
        wr_flash = reg_wr && (reg_sel == SEL_FLASH);
        wr_intr  = reg_wr && (reg_sel == SEL_INTR);
    end

    assign wdata_unused = ^{reg_wdata[DW-1:FC_WP+1], reg_wdata[FC_WP-1:FC_LOCK+1]};

    bwl_flash_ctl u_fc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_flash),
        .wd_we   (reg_wdata[FC_WE]),
        .wd_lock (reg_wdata[FC_LOCK]),
        .wd_wp   (reg_wdata[FC_WP]),
        .we_clr  (smm_we_clr),
        .we      (fc_we),
        .lock    (fc_lock),
        .wp      (fc_wp),
        .trap    (fc_trap)
    );

    bwl_intr_ctl u_ic (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_intr),
        .wd_gen  (reg_wdata[IC_GEN]),
        .wd_lock (reg_wdata[IC_LOCK]),
        .gen     (ic_gen),
        .lock    (ic_lock)
    );

    assign smi_src = {ext_smi, fc_trap};

    bwl_smi_req #(.N_SRC(N_SRC)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (smi_src),
        .gen   (ic_gen),
        .ack   (smi_ack),
        .req   (smi_req)
    );

    // read mux: unimplemented bits return 0
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_FLASH) begin
            reg_rdata[FC_WE]   = fc_we;
            reg_rdata[FC_LOCK] = fc_lock;
            reg_rdata[FC_WP]   = fc_wp;
        end else begin
            reg_rdata[IC_GEN]  = ic_gen;
            reg_rdata[IC_LOCK] = ic_lock;
        end
    end

    assign flash_wr_en = fc_we;
endmodule

// File: rtl/bwl_smi_ctrl_chk.sv
// Checker: temporal properties of the write guard, bound into the top module.
module bwl_smi_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_sel,
    input logic wd0,
    input logic fc_lock,
    input logic fc_wp,
    input logic ic_gen,
    input logic ic_lock,
    input logic smm_we_clr,
    input logic smi_ack,
    input logic flash_wr_en,
    input logic smi_req
);
    // R3
    flash_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_lock |=> fc_lock);
    // R3
    flash_wp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_wp |=> fc_wp);
    // R8
    gen_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ic_lock |=> ($stable(ic_gen) && ic_lock));
    // R5
    no_smi_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ic_gen && !smi_req) |=> !smi_req);
    // R6
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !smi_ack) |=> smi_req);
    // R7
    handler_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smm_we_clr |=> !flash_wr_en);
    // R4
    trap_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && wd0 && !flash_wr_en && (fc_lock || fc_wp)
         && ic_gen && !smm_we_clr) |=> (smi_req && flash_wr_en));
endmodule

bind bwl_smi_ctrl bwl_smi_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .wd0         (reg_wdata[0]),
    .fc_lock     (fc_lock),
    .fc_wp       (fc_wp),
    .ic_gen      (ic_gen),
    .ic_lock     (ic_lock),
    .smm_we_clr  (smm_we_clr),
    .smi_ack     (smi_ack),
    .flash_wr_en (flash_wr_en),
    .smi_req     (smi_req)
);

// File: tb/bwl_smi_ctrl_bench.sv
module bwl_smi_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smm_we_clr = 1'b0;
    logic        ext_smi = 1'b0;
    logic        smi_ack = 1'b0;
    logic        flash_wr_en;
    logic        smi_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwl_smi_ctrl u_bwl_smi_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smm_we_clr(smm_we_clr),
        .ext_smi(ext_smi), .smi_ack(smi_ack), .flash_wr_en(flash_wr_en),
        .smi_req(smi_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr = 1'b0; smm_we_clr = 1'b0; ext_smi = 1'b0; smi_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        smi_ack = 1'b1;
        @(negedge clk);
        smi_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        // R1 reset state
        do_reset();
        @(negedge clk);
        rd(1'b0, d); check("R1 flash reg", d, 32'h0);
        rd(1'b1, d); check("R1 intr reg", d, 32'h0);
        check("R1 flash_wr_en", {31'b0, flash_wr_en}, 32'h0);
        check("R1 smi_req", {31'b0, smi_req}, 32'h0);

        // R2 R4 R5 sweep of protect bits, enable, prior and written write-enable
        for (int k = 0; k < 32; k++) begin
            logic lk, wp, ge, w0, v, exp_smi;
            lk = k[0]; wp = k[1]; ge = k[2]; w0 = k[3]; v = k[4];
            do_reset();
            if (ge) wr(1'b1, 32'h1);
            wr(1'b0, {31'b0, w0});
            wr(1'b0, {26'b0, wp, 3'b0, lk, w0});
            if (smi_req) pulse_ack();
            wr(1'b0, {26'b0, wp, 3'b0, lk, v});
            exp_smi = v & !w0 & (lk | wp) & ge;
            check("R4 R5 smi_req after write", {31'b0, smi_req}, {31'b0, exp_smi});
            rd(1'b0, d);
            check("R2 R3 flash reg", d, {26'b0, wp, 3'b0, lk, v});
            check("R2 flash_wr_en", {31'b0, flash_wr_en}, {31'b0, v});
        end

        // R3 protect bits cannot be cleared by writes
        do_reset();
        wr(1'b0, 32'h22);
        wr(1'b0, 32'h0);
        rd(1'b0, d); check("R3 sticky protect bits", d, 32'h22);

        // R8 interrupt lock sweep
        for (int k = 0; k < 8; k++) begin
            logic g0, nv, locked;
            g0 = k[0]; nv = k[1]; locked = k[2];
            do_reset();
            wr(1'b1, {31'b0, g0});
            if (locked) wr(1'b1, {30'b0, 1'b1, g0});
            wr(1'b1, {31'b0, nv});
            rd(1'b1, d);
            check("R8 intr reg", d, {30'b0, locked, locked ? g0 : nv});
        end

        // R9 generic source, enabled and disabled
        for (int g = 0; g < 2; g++) begin
            do_reset();
            wr(1'b1, {31'b0, g[0]});
            @(negedge clk); ext_smi = 1'b1;
            @(negedge clk); ext_smi = 1'b0;
            check("R9 R5 ext_smi", {31'b0, smi_req}, {31'b0, g[0]});
        end

        // R6 held without ack, trigger wins over ack, then ack drops it
        do_reset();
        wr(1'b1, 32'h1);
        @(negedge clk); ext_smi = 1'b1;
        @(negedge clk); ext_smi = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 held", {31'b0, smi_req}, 32'h1);
        smi_ack = 1'b1; ext_smi = 1'b1;
        @(negedge clk); ext_smi = 1'b0; smi_ack = 1'b0;
        check("R6 trigger beats ack", {31'b0, smi_req}, 32'h1);
        pulse_ack();
        check("R6 ack clears", {31'b0, smi_req}, 32'h0);

        // R7 handler clear, alone and against a software set
        do_reset();
        wr(1'b0, 32'h1);
        @(negedge clk); smm_we_clr = 1'b1;
        @(negedge clk); smm_we_clr = 1'b0;
        check("R7 clear", {31'b0, flash_wr_en}, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h1; smm_we_clr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; smm_we_clr = 1'b0;
        check("R7 clear beats set", {31'b0, flash_wr_en}, 32'h0);

        // R10 read layout with all-ones writes
        do_reset();
        wr(1'b0, 32'hFFFF_FFFF);
        if (smi_req) pulse_ack();
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R10 flash layout", d, 32'h23);
        rd(1'b1, d); check("R10 intr layout", d, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule